// File: doc/BRIEF.md
# Byte-Level Serial Bus Slave Engine with General-Call Acceptance

This block is the slave side of a two-wire SMBus/I2C port. It is oversampled by a fast system clock. Both bus lines pass through synchronizers. The block finds START and STOP conditions and shifts in the first byte after a START. It compares the seven address bits of that byte with a programmable own address. The all-zero general-call address is also accepted when an enable bit is set. On a match the block acknowledges the byte, then works as a transmitter or a receiver, as the direction bit selects.

Software on the register side sees four things. A one-entry transmit holding byte is loaded by a strobe. The last received byte is shown on a port. An assert-acknowledge level decides whether a received data byte gets an ACK. A sticky per-byte interrupt flag is cleared by a strobe. SDA is never driven high: the block only asserts a pull-down enable, and the pad and the pull-up make the open-drain line.

Top module: `smb_slave`

## Requirements
- R1: Bus activity is ignored until a START, meaning a falling SDA while SCL is high. A byte clocked without a preceding START gets no ACK and raises no interrupt.
- R2: The first byte after a START is read MSB first. Bits 7:1 are the address and bit 0 is the direction. The byte is acknowledged (SDA pulled low in the ninth clock) when its bits 7:1 equal `ownAddrReg[7:1]`.
- R3: The address 0x00 is acknowledged only while `ownAddrReg[0]` is 1. When the address does not match, SDA stays released and the slave waits for the next START.
- R4: Direction bit 1 makes the slave a transmitter and sets `txMode` to 1. Each byte is sent MSB first from the holding byte written by `txLoad`. Direction bit 0 makes it a receiver and leaves `txMode` at 0.
- R5: If the holding byte is empty at the falling SCL edge that starts a transmit byte, 0xFF is sent. Loading the byte at that edge empties the holding register.
- R6: When the master answers a transmitted byte with NACK (SDA high in the ninth clock), the slave releases SDA and clears `txMode`. Later clocks get no data from the slave until a START or a STOP.
- R7: In receiver mode each byte is taken MSB first and shown on `rxByte`. In the ninth clock the slave returns ACK if `ackEnable` is 1 and NACK if it is 0. `ackEnable` is sampled at the falling SCL edge that opens that clock.
- R8: `irqFlag` is set in the ninth clock of every byte the slave took part in: an acknowledged address, a received byte, or a transmitted byte. It stays set until `irqClr`, and a new set wins over a clear.
- R9: A STOP (rising SDA while SCL is high) ends any mode, releases SDA and clears `txMode`.
- R10: A repeated START in any state restarts the address phase.
- R11: The SDA pull-down is only switched on while SCL is low. After reset SDA is released and `irqFlag`, `txMode` and `rxByte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line as seen at the pad |
| sdaIn | input | 1 | SDA line as seen at the pad |
| sdaDriveLow | output | 1 | Pull-down enable for SDA (1 = drive low) |
| ownAddrReg | input | 8 | Bits 7:1 own address, bit 0 general-call enable |
| ackEnable | input | 1 | ACK (1) or NACK (0) for received data bytes |
| txByte | input | 8 | Next byte to transmit |
| txLoad | input | 1 | Strobe: write `txByte` into the holding register |
| rxByte | output | 8 | Last received data byte |
| irqFlag | output | 1 | Sticky per-byte interrupt flag |
| irqClr | input | 1 | Strobe: clear `irqFlag` |
| txMode | output | 1 | Slave is in transmitter mode |

## Verification
Every pad change reaches the control after two synchronizer flops and one edge-detect flop. A strobe then takes one more clock to reach the SDA pull-down, `rxByte` or `irqFlag`. So each result is due about four system clocks after the SCL edge that causes it. The bench's master model holds each SCL phase for at least six clocks. It samples SDA in the middle of SCL high. It reads `rxByte`, `irqFlag` and `txMode` only after a whole byte task has ended with SCL low, and strobes go in at falling clock edges. Under these rules every check falls well after the result is due and before the next bus event can change it.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;

  // events the datapath reports to the control each clock
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic bitLast;   // counter sits on the last bit of a byte
    logic byteDone;  // counter has counted a whole byte
    logic addrHit;   // shifted address equals own or accepted general call
    logic sdaNow;    // synchronized SDA level
  } busEvt_t;

  // strobes the control issues to the datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shiftIn;
    logic latchRx;
    logic loadTx;
    logic shiftOut;
    logic ackDrive;
    logic sdaFree;
    logic raiseIrq;
  } ctlStb_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_RX,
    S_ACK_SET,
    S_ACK_HOLD,
    S_ACK_END,
    S_TX,
    S_MACK
  } ctlState_t;

endpackage

// File: rtl/smb_slave_dp.sv
module smb_slave_dp
  import smb_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] ownAddrReg,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txLoad,
  input  logic              irqClr,
  input  ctlStb_t           stb,
  output busEvt_t           evt,
  output logic [DATA_W-1:0] rxByte,
  output logic              irqFlag,
  output logic              driveLow
);

  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int ADDR_W = DATA_W - 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg, txHold, rxReg, loadSrc;
  logic txValid, irqReg, driveReg;
  logic [ADDR_W-1:0] addrField;

  // two-line synchronizers, one per bus wire
  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[SYNC_STAGES-2:0], (g == 0) ? sclIn : sdaIn};
    end
    if (g == 0) begin : g_scl
      assign sclPipe = pipe;
    end else begin : g_sda
      assign sdaPipe = pipe;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign addrField = shReg[ADDR_W-1:0];
  assign loadSrc   = txValid ? txHold : '1;

  always_comb begin
    evt.sclRise   = sclS & ~sclD;
    evt.sclFall   = ~sclS & sclD;
    evt.startSeen = sclS & sclD & sdaD & ~sdaS;
    evt.stopSeen  = sclS & sclD & ~sdaD & sdaS;
    evt.bitLast   = (bitCnt == CNT_W'(DATA_W - 1));
    evt.byteDone  = (bitCnt == CNT_W'(DATA_W));
    evt.addrHit   = (addrField == ownAddrReg[DATA_W-1:1]) ||
                    ((addrField == '0) && ownAddrReg[0]);
    evt.sdaNow    = sdaS;
  end

  // bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bitCnt <= '0;
    else if (stb.cntClr) bitCnt <= '0;
    else if (stb.cntInc) bitCnt <= bitCnt + 1'b1;
  end

  // shared shift register, SDA pull-down and receive latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      driveReg <= 1'b0;
      rxReg    <= '0;
    end else begin
      if (stb.shiftIn) shReg <= {shReg[DATA_W-2:0], sdaS};
      if (stb.latchRx) rxReg <= {shReg[DATA_W-2:0], sdaS};
      if (stb.loadTx) begin
        shReg    <= loadSrc;
        driveReg <= ~loadSrc[DATA_W-1];
      end else if (stb.shiftOut) begin
        shReg    <= {shReg[DATA_W-2:0], 1'b1};
        driveReg <= ~shReg[DATA_W-2];
      end else if (stb.ackDrive) begin
        driveReg <= 1'b1;
      end else if (stb.sdaFree) begin
        driveReg <= 1'b0;
      end
    end
  end

  // transmit holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txValid <= 1'b0;
    end else if (txLoad) begin
      txHold  <= txByte;
      txValid <= 1'b1;
    end else if (stb.loadTx) begin
      txValid <= 1'b0;
    end
  end

  // sticky interrupt flag, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqReg <= 1'b0;
    else if (stb.raiseIrq) irqReg <= 1'b1;
    else if (irqClr)       irqReg <= 1'b0;
  end

  assign rxByte   = rxReg;
  assign irqFlag  = irqReg;
  assign driveLow = driveReg;

  AST_PULLDOWN_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveReg) |-> !$past(sclS)) else $error("pull-down switched on with SCL high"); // R11
  AST_IRQ_IN_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReg) |-> $past(sclS)) else $error("irq outside the ninth clock high"); // R8
  AST_STOP_FREES_SDA: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopSeen |=> !driveReg) else $error("SDA still held after STOP"); // R9

endmodule

// File: rtl/smb_slave_ctl.sv
module smb_slave_ctl
  import smb_slave_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    ackEnable,
  input  logic    driveNow,
  output ctlStb_t stb,
  output logic    txMode
);

  ctlState_t state, nState;
  logic dirReg, nDir, addrAck, nAddrAck, txReg, nTx, mAckReg, nMAck;

  always_comb begin
    stb      = '0;
    nState   = state;
    nDir     = dirReg;
    nAddrAck = addrAck;
    nTx      = txReg;
    nMAck    = mAckReg;
    if (evt.startSeen) begin
      nState     = S_ADDR;
      stb.cntClr = 1'b1;
      stb.sdaFree = 1'b1;
      nTx        = 1'b0;
      nDir       = 1'b0;
    end else if (evt.stopSeen) begin
      nState      = S_IDLE;
      stb.sdaFree = 1'b1;
      nTx         = 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_ADDR: if (evt.sclRise) begin
          stb.shiftIn = 1'b1;
          stb.cntInc  = 1'b1;
          if (evt.bitLast) begin
            if (evt.addrHit) begin
              nState   = S_ACK_SET;
              nAddrAck = 1'b1;
              nDir     = evt.sdaNow;
              nTx      = evt.sdaNow;
            end else begin
              nState = S_IDLE;
            end
          end
        end
        S_RX: if (evt.sclRise) begin
          stb.shiftIn = 1'b1;
          stb.cntInc  = 1'b1;
          if (evt.bitLast) begin
            stb.latchRx = 1'b1;
            nAddrAck    = 1'b0;
            nState      = S_ACK_SET;
          end
        end
        S_ACK_SET: if (evt.sclFall) begin
          stb.ackDrive = addrAck | ackEnable;
          nState       = S_ACK_HOLD;
        end
        S_ACK_HOLD: if (evt.sclRise) begin
          stb.raiseIrq = 1'b1;
          nState       = S_ACK_END;
        end
        S_ACK_END: if (evt.sclFall) begin
          stb.cntClr = 1'b1;
          if (dirReg) begin
            stb.loadTx = 1'b1;
            nState     = S_TX;
          end else begin
            stb.sdaFree = 1'b1;
            nState      = S_RX;
          end
        end
        S_TX: begin
          if (evt.sclRise) begin
            stb.cntInc = 1'b1;
          end else if (evt.sclFall) begin
            if (evt.byteDone) begin
              stb.sdaFree = 1'b1;
              nState      = S_MACK;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        S_MACK: begin
          if (evt.sclRise) begin
            stb.raiseIrq = 1'b1;
            nMAck        = ~evt.sdaNow;
          end else if (evt.sclFall) begin
            if (mAckReg) begin
              stb.loadTx = 1'b1;
              stb.cntClr = 1'b1;
              nState     = S_TX;
            end else begin
              nState = S_IDLE;
              nTx    = 1'b0;
            end
          end
        end
        default: nState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      dirReg  <= 1'b0;
      addrAck <= 1'b0;
      txReg   <= 1'b0;
      mAckReg <= 1'b0;
    end else begin
      state   <= nState;
      dirReg  <= nDir;
      addrAck <= nAddrAck;
      txReg   <= nTx;
      mAckReg <= nMAck;
    end
  end

  assign txMode = txReg;

  AST_START_OPENS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    evt.startSeen |=> (state == S_ADDR)) else $error("START did not restart address phase"); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !driveNow) else $error("SDA held while idle"); // R6
  AST_NACK_POLICY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACK_SET && evt.sclFall && !addrAck && !ackEnable) |=> !driveNow)
    else $error("receive ACK given while acknowledge disabled"); // R7
  AST_ONE_SDA_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadTx, stb.shiftOut, stb.ackDrive, stb.sdaFree}))
    else $error("conflicting SDA actions"); // R11
  AST_TXMODE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReg) |-> $past(state) == S_ADDR) else $error("txMode set outside address phase"); // R4

endmodule

// File: rtl/smb_slave.sv
module smb_slave
  import smb_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [DATA_W-1:0] ownAddrReg,
  input  logic              ackEnable,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txLoad,
  output logic [DATA_W-1:0] rxByte,
  output logic              irqFlag,
  input  logic              irqClr,
  output logic              txMode
);

  busEvt_t evt;
  ctlStb_t stb;
  logic    driveLow;

  smb_slave_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddrReg(ownAddrReg), .txByte(txByte), .txLoad(txLoad),
    .irqClr(irqClr), .stb(stb), .evt(evt), .rxByte(rxByte),
    .irqFlag(irqFlag), .driveLow(driveLow)
  );

  smb_slave_ctl ctl_i (
    .clk(clk), .rstN(rstN), .evt(evt), .ackEnable(ackEnable),
    .driveNow(driveLow), .stb(stb), .txMode(txMode)
  );

  assign sdaDriveLow = driveLow;

endmodule

// File: tb/smb_slave_tb_top.sv
module smb_slave_tb_top;
  localparam int Q = 6;
  localparam int H = 12;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, mScl, mSda, ackEnable, txLoad, irqClr;
  logic [7:0] ownAddrReg, txByte, rxByte;
  logic sdaDriveLow, irqFlag, txMode;
  wire  sdaBus = mSda & ~sdaDriveLow;

  int total = 0, bad = 0, edgeViol = 0;
  logic prevDrive = 1'b0;

  smb_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .ownAddrReg(ownAddrReg), .ackEnable(ackEnable),
    .txByte(txByte), .txLoad(txLoad), .rxByte(rxByte), .irqFlag(irqFlag),
    .irqClr(irqClr), .txMode(txMode)
  );

  // pull-down may only come on while SCL is low (R11)
  always @(negedge clk) begin
    if (rstN && sdaDriveLow && !prevDrive && mScl) edgeViol++;
    prevDrive = sdaDriveLow;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    mSda = 1'b1; w(Q); mScl = 1'b1; w(H); mSda = 1'b0; w(H); mScl = 1'b0; w(Q);
  endtask

  task automatic stopC();
    mSda = 1'b0; w(Q); mScl = 1'b1; w(H); mSda = 1'b1; w(H);
  endtask

  task automatic writeBit(input logic b);
    mSda = b; w(Q); mScl = 1'b1; w(H); mScl = 1'b0; w(Q);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; w(Q); mScl = 1'b1; w(H/2); b = sdaBus; w(H/2); mScl = 1'b0; w(Q);
  endtask

  task automatic loadTx(input logic [7:0] v);
    txByte = v; txLoad = 1'b1; w(1); txLoad = 1'b0;
  endtask

  task automatic clrIrq();
    irqClr = 1'b1; w(1); irqClr = 1'b0; w(1);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic mAck,
                          input logic doPre, input logic [7:0] pre);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
      if (i == 4 && doPre) loadTx(pre);
    end
    writeBit(~mAck);
  endtask

  initial begin
    logic ack;
    logic [7:0] got;
    rstN = 1'b0; mScl = 1'b1; mSda = 1'b1; ackEnable = 1'b1;
    txLoad = 1'b0; irqClr = 1'b0; txByte = 8'h00; ownAddrReg = {OWN, 1'b0};
    w(5); rstN = 1'b1; w(5);

    // R11 reset state
    chk(!sdaDriveLow && !irqFlag && !txMode && rxByte == 8'h00, "R11 reset",
        {sdaDriveLow, irqFlag, txMode, rxByte}, 0);

    // R2 R3 sweep all write addresses, general call disabled
    for (int a = 0; a < 128; a++) begin
      startC();
      sendByte({7'(a), 1'b0}, ack);
      chk(ack == (a == int'(OWN)), "R2 address ack", ack, (a == int'(OWN)));
      chk(irqFlag == ack, "R8 irq on address ack", irqFlag, ack);
      chk(!txMode, "R4 write keeps txMode 0", txMode, 0);
      stopC();
      clrIrq();
    end

    // R3 general call enabled, both directions
    ownAddrReg = {OWN, 1'b1};
    for (int d = 0; d < 2; d++) begin
      startC();
      sendByte({7'h00, 1'(d)}, ack);
      chk(ack, "R3 general call ack", ack, 1);
      chk(txMode == 1'(d), "R4 direction sets txMode", txMode, d);
      stopC();
      chk(!txMode && !sdaDriveLow, "R9 stop ends mode", {txMode, sdaDriveLow}, 0);
      clrIrq();
    end

    // R7 R8 receiver: bytes with ACK, then one with NACK
    startC();
    sendByte({OWN, 1'b0}, ack);
    clrIrq();
    for (int i = 0; i < 10; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 37) ^ 8'h81);
      sendByte(v, ack);
      chk(ack, "R7 ack with ackEnable", ack, 1);
      chk(rxByte == v, "R7 received byte", rxByte, v);
      chk(irqFlag, "R8 irq after data byte", irqFlag, 1);
      clrIrq();
      chk(!irqFlag, "R8 irq cleared", irqFlag, 0);
    end
    ackEnable = 1'b0;
    sendByte(8'hC3, ack);
    chk(!ack, "R7 nack with ackEnable 0", ack, 0);
    chk(rxByte == 8'hC3, "R7 byte kept on nack", rxByte, 8'hC3);
    chk(irqFlag, "R8 irq after nacked byte", irqFlag, 1);
    ackEnable = 1'b1;
    stopC();
    clrIrq();
    chk(!sdaDriveLow, "R9 released after stop", sdaDriveLow, 0);

    // R1 byte without START is ignored
    sendByte({OWN, 1'b0}, ack);
    chk(!ack, "R1 no ack without start", ack, 0);
    chk(!irqFlag, "R1 no irq without start", irqFlag, 0);
    stopC();

    // R4 R5 R6 transmitter
    loadTx(8'hA5);
    startC();
    sendByte({OWN, 1'b1}, ack);
    chk(ack && txMode, "R4 read address ack", {ack, txMode}, 2'b11);
    clrIrq();
    recvByte(got, 1'b1, 1'b1, 8'h3C);
    chk(got == 8'hA5, "R4 first tx byte", got, 8'hA5);
    chk(irqFlag, "R8 irq after tx byte", irqFlag, 1);
    clrIrq();
    recvByte(got, 1'b1, 1'b0, 8'h00);
    chk(got == 8'h3C, "R4 second tx byte", got, 8'h3C);
    recvByte(got, 1'b0, 1'b0, 8'h00);
    chk(got == 8'hFF, "R5 empty holding sends FF", got, 8'hFF);
    chk(!sdaDriveLow && !txMode, "R6 released after master nack",
        {sdaDriveLow, txMode}, 0);
    loadTx(8'h00);
    recvByte(got, 1'b1, 1'b0, 8'h00);
    chk(got == 8'hFF, "R6 no data after nack", got, 8'hFF);
    stopC();
    clrIrq();

    // R10 repeated START during a write switches to a read
    startC();
    sendByte({OWN, 1'b0}, ack);
    sendByte(8'h11, ack);
    chk(ack && rxByte == 8'h11, "R10 byte before restart", rxByte, 8'h11);
    loadTx(8'h77);
    startC();
    sendByte({OWN, 1'b1}, ack);
    chk(ack && txMode, "R10 address after restart", {ack, txMode}, 2'b11);
    recvByte(got, 1'b0, 1'b0, 8'h00);
    chk(got == 8'h77, "R10 read after restart", got, 8'h77);
    stopC();

    chk(edgeViol == 0, "R11 pull-down only with SCL low", edgeViol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    w(150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule